// File: doc/BRIEF.md
# Memory Region Access Judge

This block rules on a single memory access: may it go ahead or not? The access arrives with a start address, a byte count and the rights it asks for (read, write, execute). The block also receives a set of region entries that an upstream decoder has already turned into inclusive low and high byte bounds. With them come each entry's configuration byte, its resolved lock flag, the current privilege level and the number of active entries.

Every entry is evaluated in parallel. The touched entry with the lowest index settles the outcome. The verdict, a hit flag and the index of the deciding entry are registered and presented one cycle after a valid request. Register access, bound decoding and raising any fault are handled elsewhere.

Top module: `prot_access_judge`

## Requirements
- R1: When the active-entry count input is zero, every request is allowed and reported with hit 0 and index 0, whatever the entries hold.
- R2: Among the entries the access touches, the one with the lowest index decides, even if a higher entry would give a different verdict.
- R3: If exactly one of the first byte and the last byte lies inside the deciding entry's bounds, the access is denied and reported with hit 1 and that entry's index.
- R4: If both bytes lie inside the deciding entry and the requester is not in machine mode, or the entry is locked, the access is allowed only when every requested right is set in the entry's configuration byte. Read is bit 0, write is bit 1 and execute is bit 2, in both the request and the configuration byte.
- R5: In machine mode, an entry that fully contains the access and is not locked allows it whatever its right bits say.
- R6: If no entry is touched while the count is nonzero, a machine-mode access is allowed and any other access is denied, reported with hit 0 and index 0.
- R7: An entry whose mode field (configuration bits 4:3) is zero is skipped and never touches an access.
- R8: The last byte is the address plus the size minus one, taken modulo 2 to the power of the address width.
- R9: The response valid is high exactly in the cycle after a request valid. The verdict, hit and index change only after a request and hold otherwise.
- R10: During reset the response valid, verdict, hit and index are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | First byte address |
| req_size | input | SW | Access size in bytes |
| req_rights | input | 3 | Requested rights: bit 0 read, bit 1 write, bit 2 execute |
| priv_mach | input | 1 | Requester is in machine mode |
| rule_count | input | CW | Number of active entries |
| ent_lo | input | NUM_ENT*AW | Inclusive low bound per entry, entry i at bits i*AW |
| ent_hi | input | NUM_ENT*AW | Inclusive high bound per entry |
| ent_cfg | input | NUM_ENT*8 | Configuration byte per entry: rights in bits 2:0, mode in bits 4:3 |
| ent_lock | input | NUM_ENT | Resolved lock flag per entry |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | Access allowed |
| rsp_hit | output | 1 | An entry decided the verdict |
| rsp_index | output | IW | Index of the deciding entry, 0 when there is no hit |

## Verification
The bench runs four entry sets over every address of an 8-bit space. Each address is tried with four sizes, four right combinations and both privilege levels. One set has overlapping entries with mixed locks, so lowest-index priority, partial overlap and machine-mode bypass give different answers at neighbouring addresses. Another set has active entries but a zero count, which tells the count shortcut apart from the normal scan. A third set places an entry at the top of the space so that sizes running past the end wrap the last byte, and a sparse set exposes the no-match path for both privilege levels. Directed cases then pin down an overlap decided by the lower entry, a disabled entry covering the whole space, the exact last-byte boundary, and holding of the outputs between requests.

// File: rtl/prot_judge_pkg.sv
package prot_judge_pkg;
  localparam int RIGHT_W  = 3;
  localparam int MODE_LSB = 3;
  localparam int MODE_MSB = 4;
  localparam int CFG_W    = 8;
  localparam logic [1:0] MODE_DISABLED = 2'b00;
endpackage

// File: rtl/prot_entry_eval.sv
module prot_entry_eval
  import prot_judge_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]      lo,
  input  logic [AW-1:0]      hi,
  input  logic [AW-1:0]      first_b,
  input  logic [AW-1:0]      last_b,
  input  logic [CFG_W-1:0]   cfg,
  input  logic               locked,
  input  logic               priv_mach,
  input  logic [RIGHT_W-1:0] rights,
  output logic               touch,
  output logic               ok
);
  logic               active;
  logic               in_first;
  logic               in_last;
  logic               full;
  logic [RIGHT_W-1:0] grant;

  always_comb begin
    active   = cfg[MODE_MSB:MODE_LSB] != MODE_DISABLED;
    in_first = (first_b >= lo) && (first_b <= hi);
    in_last  = (last_b >= lo) && (last_b <= hi);
    full     = active && in_first && in_last;
    touch    = active && (in_first || in_last);
    grant    = (priv_mach && !locked) ? {RIGHT_W{1'b1}} : cfg[RIGHT_W-1:0];
    ok       = full && ((rights & ~grant) == '0);
  end
endmodule

// File: rtl/prot_prio_pick.sv
module prot_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/prot_rsp_stage.sv
module prot_rsp_stage #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_allow,
  input  logic          in_hit,
  input  logic [IW-1:0] in_index,
  output logic          out_valid,
  output logic          out_allow,
  output logic          out_hit,
  output logic [IW-1:0] out_index
);
  logic          valid_q, allow_q, hit_q;
  logic [IW-1:0] index_q;
  logic          valid_d, allow_d, hit_d;
  logic [IW-1:0] index_d;

  always_comb begin
    valid_d = in_valid;
    allow_d = allow_q;
    hit_d   = hit_q;
    index_d = index_q;
    if (in_valid) begin
      allow_d = in_allow;
      hit_d   = in_hit;
      index_d = in_index;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      allow_q <= 1'b0;
      hit_q   <= 1'b0;
      index_q <= '0;
    end else begin
      valid_q <= valid_d;
      allow_q <= allow_d;
      hit_q   <= hit_d;
      index_q <= index_d;
    end
  end

  assign out_valid = valid_q;
  assign out_allow = allow_q;
  assign out_hit   = hit_q;
  assign out_index = index_q;
endmodule

// File: rtl/prot_access_judge.sv
module prot_access_judge
  import prot_judge_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int AW      = 32,
  parameter int SW      = 4,
  localparam int IW     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int CW     = $clog2(NUM_ENT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [AW-1:0]            req_addr,
  input  logic [SW-1:0]            req_size,
  input  logic [RIGHT_W-1:0]       req_rights,
  input  logic                     priv_mach,
  input  logic [CW-1:0]            rule_count,
  input  logic [NUM_ENT*AW-1:0]    ent_lo,
  input  logic [NUM_ENT*AW-1:0]    ent_hi,
  input  logic [NUM_ENT*CFG_W-1:0] ent_cfg,
  input  logic [NUM_ENT-1:0]       ent_lock,
  output logic                     rsp_valid,
  output logic                     rsp_allow,
  output logic                     rsp_hit,
  output logic [IW-1:0]            rsp_index
);
  logic [AW-1:0]      last_b;
  logic [NUM_ENT-1:0] touch_vec;
  logic [NUM_ENT-1:0] ok_vec;
  logic               any_touch;
  logic [IW-1:0]      pick_idx;
  logic               dec_allow;
  logic               dec_hit;
  logic [IW-1:0]      dec_index;

  assign last_b = req_addr + AW'(req_size) - AW'(1);

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    prot_entry_eval #(.AW(AW)) eval_i (
      .lo        (ent_lo[g*AW +: AW]),
      .hi        (ent_hi[g*AW +: AW]),
      .first_b   (req_addr),
      .last_b    (last_b),
      .cfg       (ent_cfg[g*CFG_W +: CFG_W]),
      .locked    (ent_lock[g]),
      .priv_mach (priv_mach),
      .rights    (req_rights),
      .touch     (touch_vec[g]),
      .ok        (ok_vec[g])
    );
  end

  prot_prio_pick #(.N(NUM_ENT), .IW(IW)) pick_i (
    .req   (touch_vec),
    .found (any_touch),
    .idx   (pick_idx)
  );

  always_comb begin
    dec_allow = priv_mach;
    dec_hit   = 1'b0;
    dec_index = '0;
    if (rule_count == '0) begin
      dec_allow = 1'b1;
    end else if (any_touch) begin
      dec_allow = ok_vec[pick_idx];
      dec_hit   = 1'b1;
      dec_index = pick_idx;
    end
  end

  prot_rsp_stage #(.IW(IW)) rsp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_allow  (dec_allow),
    .in_hit    (dec_hit),
    .in_index  (dec_index),
    .out_valid (rsp_valid),
    .out_allow (rsp_allow),
    .out_hit   (rsp_hit),
    .out_index (rsp_index)
  );
endmodule

// File: rtl/prot_access_judge_chk.sv
module prot_access_judge_chk
  import prot_judge_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int AW      = 32,
  parameter int SW      = 4,
  localparam int IW     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int CW     = $clog2(NUM_ENT + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     priv_mach,
  input logic [CW-1:0]            rule_count,
  input logic [NUM_ENT*CFG_W-1:0] ent_cfg,
  input logic                     rsp_valid,
  input logic                     rsp_allow,
  input logic                     rsp_hit,
  input logic [IW-1:0]            rsp_index
);
  logic all_off;

  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ent_cfg[i*CFG_W + MODE_LSB +: 2] != MODE_DISABLED) all_off = 1'b0;
    end
  end

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_allow) && $stable(rsp_hit) && $stable(rsp_index)));

  assert_empty_allows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rule_count == '0) |=> (rsp_allow && !rsp_hit));

  assert_nomatch_by_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rule_count != '0) |=> (rsp_hit || (rsp_allow == $past(priv_mach))));

  assert_disabled_skipped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && all_off) |=> !rsp_hit);
endmodule

bind prot_access_judge prot_access_judge_chk #(
  .NUM_ENT(NUM_ENT), .AW(AW), .SW(SW)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .priv_mach  (priv_mach),
  .rule_count (rule_count),
  .ent_cfg    (ent_cfg),
  .rsp_valid  (rsp_valid),
  .rsp_allow  (rsp_allow),
  .rsp_hit    (rsp_hit),
  .rsp_index  (rsp_index)
);

// File: tb/prot_access_judge_tb_top.sv
module prot_access_judge_tb_top;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int SW = 4;
  localparam int IW = 2;
  localparam int CW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [SW-1:0]   req_size = 4'd1;
  logic [2:0]      req_rights = 3'd0;
  logic            priv_mach = 1'b0;
  logic [CW-1:0]   rule_count = '0;
  logic [N*AW-1:0] ent_lo;
  logic [N*AW-1:0] ent_hi;
  logic [N*8-1:0]  ent_cfg;
  logic [N-1:0]    ent_lock;
  logic            rsp_valid, rsp_allow, rsp_hit;
  logic [IW-1:0]   rsp_index;

  logic [AW-1:0] b_lo [N];
  logic [AW-1:0] b_hi [N];
  logic [1:0]    b_mode [N];
  logic [2:0]    b_rwx [N];
  logic          b_lock [N];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_lo[i*AW +: AW] = b_lo[i];
      ent_hi[i*AW +: AW] = b_hi[i];
      ent_cfg[i*8 +: 8]  = {3'b000, b_mode[i], b_rwx[i]};
      ent_lock[i]        = b_lock[i];
    end
  end

  prot_access_judge #(.NUM_ENT(N), .AW(AW), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_rights(req_rights), .priv_mach(priv_mach),
    .rule_count(rule_count), .ent_lo(ent_lo), .ent_hi(ent_hi),
    .ent_cfg(ent_cfg), .ent_lock(ent_lock), .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow), .rsp_hit(rsp_hit), .rsp_index(rsp_index)
  );

  task automatic set_ent(int i, int lo, int hi, int mode, int rwx, bit lk);
    b_lo[i] = AW'(lo); b_hi[i] = AW'(hi);
    b_mode[i] = 2'(mode); b_rwx[i] = 3'(rwx); b_lock[i] = lk;
  endtask

  task automatic load_set(int sel);
    int cnt;
    case (sel)
      0, 1: begin
        set_ent(0, 8'h10, 8'h1F, 1, 3'b001, 0);
        set_ent(1, 8'h18, 8'h3F, 2, 3'b011, 1);
        set_ent(2, 8'h80, 8'hBF, 3, 3'b100, 0);
        set_ent(3, 8'h00, 8'hFF, 0, 3'b111, 0);
      end
      2: begin
        set_ent(0, 8'hF0, 8'hFF, 3, 3'b111, 1);
        set_ent(1, 8'h00, 8'h0F, 1, 3'b000, 0);
        set_ent(2, 8'h40, 8'h7F, 2, 3'b010, 1);
        set_ent(3, 8'h60, 8'h9F, 3, 3'b001, 0);
      end
      default: begin
        set_ent(0, 8'h00, 8'hFF, 0, 3'b111, 0);
        set_ent(1, 8'h00, 8'hFF, 0, 3'b111, 1);
        set_ent(2, 8'h00, 8'hFF, 0, 3'b000, 0);
        set_ent(3, 8'h20, 8'h2F, 1, 3'b011, 0);
      end
    endcase
    cnt = 0;
    for (int i = 0; i < N; i++) if (b_mode[i] != 2'b00) cnt++;
    rule_count = (sel == 1) ? '0 : CW'(cnt);
  endtask

  // Reference: arithmetic evaluation from the requirement text.
  task automatic model(input int addr, input int size, input int rights, input bit mach,
                       output bit e_allow, output bit e_hit, output int e_idx,
                       output string tag);
    int last;
    bit f, l;
    int grant;
    last = (addr + size - 1) % 256;
    e_allow = mach; e_hit = 0; e_idx = 0; tag = "R6";
    if (rule_count == 0) begin
      e_allow = 1; tag = "R1";
      return;
    end
    for (int i = 0; i < N; i++) begin
      if (b_mode[i] == 2'b00) continue;
      f = (addr >= int'(b_lo[i])) && (addr <= int'(b_hi[i]));
      l = (last >= int'(b_lo[i])) && (last <= int'(b_hi[i]));
      if (!f && !l) continue;
      e_hit = 1; e_idx = i;
      if (f != l) begin
        e_allow = 0; tag = "R3";
      end else if (mach && !b_lock[i]) begin
        e_allow = 1; tag = "R5";
      end else begin
        grant = int'(b_rwx[i]);
        e_allow = ((rights & ~grant) & 7) == 0; tag = "R4";
      end
      return;
    end
  endtask

  task automatic check_rsp(string tag, bit e_allow, bit e_hit, int e_idx);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_allow !== e_allow || rsp_hit !== e_hit ||
        int'(rsp_index) != e_idx) begin
      failures++;
      $display("FAIL %s: got valid=%0b allow=%0b hit=%0b idx=%0d expected valid=1 allow=%0b hit=%0b idx=%0d",
               tag, rsp_valid, rsp_allow, rsp_hit, rsp_index, e_allow, e_hit, e_idx);
    end
  endtask

  task automatic issue(int addr, int size, int rights, bit mach);
    @(negedge clk);
    req_addr = AW'(addr); req_size = SW'(size);
    req_rights = 3'(rights); priv_mach = mach; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_model_check(string tag_override, int addr, int size, int rights, bit mach);
    bit ea, eh; int ei; string tg;
    issue(addr, size, rights, mach);
    model(addr, size, rights, mach, ea, eh, ei, tg);
    check_rsp((tag_override.len() != 0) ? tag_override : tg, ea, eh, ei);
  endtask

  task automatic check_direct(string tag, int addr, int size, int rights, bit mach,
                              bit ea, bit eh, int ei);
    issue(addr, size, rights, mach);
    check_rsp(tag, ea, eh, ei);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got run still active expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rsel [4] = '{1, 2, 4, 6};
    int szs  [4] = '{1, 2, 4, 8};
    logic          h_allow, h_hit;
    logic [IW-1:0] h_idx;
    load_set(0);
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_hit !== 1'b0 || rsp_index !== '0) begin
      failures++;
      $display("FAIL R10: got valid=%0b allow=%0b hit=%0b idx=%0d expected all zero",
               rsp_valid, rsp_allow, rsp_hit, rsp_index);
    end
    @(negedge clk) rst_n = 1'b1;

    // R2: overlap 0x18..0x1F decided by entry 0 (read-only) not entry 1 (read/write)
    load_set(0);
    check_direct("R2", 8'h18, 4, 3'b001, 0, 1, 1, 0);
    check_direct("R2", 8'h18, 4, 3'b010, 0, 0, 1, 0);
    // R7: disabled entry 3 spans all; lower privilege outside others is a miss
    check_direct("R7", 8'h50, 1, 3'b001, 0, 0, 0, 0);
    check_direct("R7", 8'h50, 1, 3'b001, 1, 1, 0, 0);
    // R8: last-byte boundary at top of entry 0 and wrap at top of space
    check_direct("R8", 8'h1C, 4, 3'b001, 0, 1, 1, 0);
    check_direct("R8", 8'h1D, 4, 3'b001, 0, 0, 1, 0);
    load_set(2);
    check_direct("R8", 8'hFC, 4, 3'b001, 1, 1, 1, 0);
    check_direct("R8", 8'hFE, 4, 3'b001, 1, 0, 1, 0);

    // R9: outputs hold and valid drops when no request
    check_direct("R9", 8'h05, 1, 3'b001, 1, 1, 1, 1);
    h_allow = rsp_allow; h_hit = rsp_hit; h_idx = rsp_index;
    @(negedge clk);
    req_addr = 8'h50; priv_mach = 1'b0; req_rights = 3'b111;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_allow !== h_allow || rsp_hit !== h_hit || rsp_index !== h_idx) begin
      failures++;
      $display("FAIL R9: got valid=%0b allow=%0b hit=%0b idx=%0d expected valid=0 allow=%0b hit=%0b idx=%0d",
               rsp_valid, rsp_allow, rsp_hit, rsp_index, h_allow, h_hit, h_idx);
    end

    // Sweeps over every address for each entry set
    for (int s = 0; s < 4; s++) begin
      load_set(s);
      for (int p = 0; p < 2; p++)
        for (int r = 0; r < 4; r++)
          for (int z = 0; z < 4; z++)
            for (int a = 0; a < 256; a++)
              run_model_check("", a, szs[z], rsel[r], p[0]);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule